// File: doc/BRIEF.md
# Control-Word Execution Unit

This block is the execution stage of a small single-cycle datapath. It takes a first operand X and a second operand Y. A field of the control word can swap in a sign-extended immediate for Y. The unit then computes a result in one of three sub-units:

- an adder/subtractor;
- a bidirectional barrel shifter, whose direction comes from the sign of the amount;
- a two-input logic unit, whose operation is written as a four-entry truth table.

The whole unit is combinational. The result reaches the shared Z result bus only when the ALU enable of the control word is set. A separate flag tells the surrounding bus logic that the unit is driving in that cycle.

The control inputs are the unit select, the add/subtract mode, the logic truth table, the shift kind, the immediate enable and the ALU enable. They are all plain levels, held for the cycle by the microcode sequencer. No data handshake exists: an operand pair presented in a cycle produces its result in that same cycle.

Top module: `ctl_alu`

## Requirements
- R1: With unit_sel = 2'b00 and sub_mode = 0, z_data equals X plus the second operand, modulo 2^W.
- R2: With unit_sel = 2'b00 and sub_mode = 1, z_data equals X minus the second operand, modulo 2^W.
- R3: With unit_sel = 2'b10, bit i of z_data equals logic_fn[{X[i], Yeff[i]}], with X as the high index bit. So 4'b1000 gives AND, 4'b1110 gives OR, 4'b0110 gives XOR and 4'b0101 gives NOT Y.
- R4: With unit_sel = 2'b01, the second operand is a signed shift amount. A positive or zero value shifts right and a negative value shifts left. The distance is the low log2(W) bits of the amount's absolute value, so an amount of zero passes X unchanged.
- R5: Shift kind 2'b00 (logical) fills the vacated bits with zeros in both directions.
- R6: Shift kind 2'b01 (arithmetic) copies X's sign bit into the vacated bits on a right shift. On a left shift it gives the same result as a logical left shift.
- R7: Shift kind 2'b10 rotates: bits leaving one end re-enter at the other end, in the direction given by the sign.
- R8: Shift kind 2'b11 is reserved. With unit_sel = 2'b01 it yields an all-zero result.
- R9: unit_sel = 2'b11 is reserved and yields an all-zero result.
- R10: When imm_en = 1, the second operand for every sub-unit is imm_val sign-extended from IMM_W bits to W bits, and y_opnd is ignored. When imm_en = 0 the second operand is y_opnd.
- R11: When alu_en = 0, z_drive is 0 and z_data is all zeros. When alu_en = 1, z_drive is 1 and z_data carries the selected result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_opnd | input | W | First operand (shift source for the shifter) |
| y_opnd | input | W | Second operand from the register file |
| imm_val | input | IMM_W | Immediate, sign-extended when used |
| imm_en | input | 1 | Use the immediate as the second operand |
| unit_sel | input | 2 | Sub-unit select: 00 arithmetic, 01 shift, 10 logic, 11 reserved |
| sub_mode | input | 1 | 0 add, 1 subtract |
| logic_fn | input | 4 | Truth table of the logic unit, indexed by {x, y} |
| shift_kind | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 reserved |
| alu_en | input | 1 | Drive the result onto the Z bus |
| z_data | output | W | Result bus value (zero when not driving) |
| z_drive | output | 1 | High while the unit drives the Z bus |

## Verification
Two functions can act on the same operation: immediate substitution and shift-direction decoding. A negative immediate must both replace Y and turn the shift to the left.

The bench provokes this in two ways:
- It sets imm_en with small negative and positive immediates while y_opnd holds a large value of the opposite sign. A wrong direction or a wrong operand source then gives a visibly different result.
- It runs the same overlap through the adder and the logic unit.

Each result is judged against a reference built from the language's own shift, add and bitwise operators.

// File: rtl/ctl_alu_pkg.sv
package ctl_alu_pkg;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'b00,
    UNIT_SHIFT = 2'b01,
    UNIT_LOGIC = 2'b10,
    UNIT_RSVD  = 2'b11
  } unit_e;

  typedef enum logic [1:0] {
    SHK_LOGICAL = 2'b00,
    SHK_ARITH   = 2'b01,
    SHK_ROTATE  = 2'b10,
    SHK_RSVD    = 2'b11
  } shift_kind_e;

endpackage

// File: rtl/ctl_alu_addsub.sv
module ctl_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  output logic [W-1:0] sum
);
  logic [W-1:0] opb_cond;

  // Two's complement subtraction: invert the second operand and add a carry-in of 1.
  assign opb_cond = opb ^ {W{sub}};
  assign sum      = opa + opb_cond + {{(W-1){1'b0}}, sub};
endmodule

// File: rtl/ctl_alu_logic.sv
module ctl_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   fn,
  output logic [W-1:0] res
);
  // Each bit looks up its own truth-table entry, indexed by {a, b}.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign res[i] = fn[{opa[i], opb[i]}];
  end
endmodule

// File: rtl/ctl_alu_shifter.sv
module ctl_alu_shifter
  import ctl_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] amt,
  input  logic [1:0]   kind,
  output logic [W-1:0] res
);
  localparam int SHW = $clog2(W);

  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = v[W-1-k];
    return r;
  endfunction

  shift_kind_e    kind_e;
  logic           go_left;
  logic [W-1:0]   amt_neg;
  logic [SHW-1:0] mag;
  logic           fill;
  logic           rot;
  logic [W-1:0]   stg [0:SHW];

  assign kind_e  = shift_kind_e'(kind);
  assign go_left = amt[W-1];
  assign amt_neg = -amt;
  assign mag     = go_left ? amt_neg[SHW-1:0] : amt[SHW-1:0];
  assign rot     = (kind_e == SHK_ROTATE);
  assign fill    = (kind_e == SHK_ARITH) && !go_left && src[W-1];

  // Left shifts reuse the right-shift network on a bit-reversed word.
  assign stg[0] = go_left ? bit_rev(src) : src;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int S = 1 << i;
    logic [W-1:0] moved;
    assign moved      = rot ? {stg[i][S-1:0], stg[i][W-1:S]}
                            : {{S{fill}}, stg[i][W-1:S]};
    assign stg[i+1]   = mag[i] ? moved : stg[i];
  end

  always_comb begin
    if (kind_e == SHK_RSVD) res = '0;
    else if (go_left)       res = bit_rev(stg[SHW]);
    else                    res = stg[SHW];
  end
endmodule

// File: rtl/ctl_alu.sv
module ctl_alu
  import ctl_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 8
) (
  input  logic [W-1:0]     x_opnd,
  input  logic [W-1:0]     y_opnd,
  input  logic [IMM_W-1:0] imm_val,
  input  logic             imm_en,
  input  logic [1:0]       unit_sel,
  input  logic             sub_mode,
  input  logic [3:0]       logic_fn,
  input  logic [1:0]       shift_kind,
  input  logic             alu_en,
  output logic [W-1:0]     z_data,
  output logic             z_drive
);
  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] imm_ext;
  logic [W-1:0] y_eff;
  logic [W-1:0] r_arith;
  logic [W-1:0] r_shift;
  logic [W-1:0] r_logic;
  logic [W-1:0] r_sel;
  unit_e        unit;

  assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
  assign y_eff   = imm_en ? imm_ext : y_opnd;
  assign unit    = unit_e'(unit_sel);

  ctl_alu_addsub #(.W(W)) u_arith (
    .opa (x_opnd),
    .opb (y_eff),
    .sub (sub_mode),
    .sum (r_arith)
  );

  ctl_alu_shifter #(.W(W)) u_shift (
    .src  (x_opnd),
    .amt  (y_eff),
    .kind (shift_kind),
    .res  (r_shift)
  );

  ctl_alu_logic #(.W(W)) u_logic (
    .opa (x_opnd),
    .opb (y_eff),
    .fn  (logic_fn),
    .res (r_logic)
  );

  always_comb begin
    unique case (unit)
      UNIT_ARITH: r_sel = r_arith;
      UNIT_SHIFT: r_sel = r_shift;
      UNIT_LOGIC: r_sel = r_logic;
      default:    r_sel = '0;
    endcase
  end

  assign z_data  = alu_en ? r_sel : '0;
  assign z_drive = alu_en;
endmodule

// File: rtl/ctl_alu_chk.sv
module ctl_alu_chk #(
  parameter int W     = 32,
  parameter int IMM_W = 8
) (
  input logic [W-1:0]     x_opnd,
  input logic [W-1:0]     y_opnd,
  input logic [IMM_W-1:0] imm_val,
  input logic             imm_en,
  input logic [1:0]       unit_sel,
  input logic             sub_mode,
  input logic [3:0]       logic_fn,
  input logic [1:0]       shift_kind,
  input logic             alu_en,
  input logic [W-1:0]     z_data,
  input logic             z_drive
);
  logic [W-1:0] yv;
  assign yv = imm_en ? W'($signed(imm_val)) : y_opnd;

  always_comb begin
    // R11: when idle, the unit leaves the bus at zero and does not claim it
    if (!alu_en) a_r11_idle_quiet: assert (z_data == '0 && !z_drive);
    if (alu_en)  a_r11_drive_flag: assert (z_drive);
    // R9: the reserved unit select gives zero
    if (alu_en && unit_sel == 2'b11) a_r9_rsvd_unit: assert (z_data == '0);
    // R8: the reserved shift kind gives zero
    if (alu_en && unit_sel == 2'b01 && shift_kind == 2'b11)
      a_r8_rsvd_shift: assert (z_data == '0);
    // R1: addition matches the sum of the operands
    if (alu_en && unit_sel == 2'b00 && !sub_mode)
      a_r1_add_sum: assert (z_data == x_opnd + yv);
    // R3: truth table 1000 behaves as AND
    if (alu_en && unit_sel == 2'b10 && logic_fn == 4'b1000)
      a_r3_and_code: assert (z_data == (x_opnd & yv));
    // R4: a zero amount passes the source unchanged
    if (alu_en && unit_sel == 2'b01 && shift_kind != 2'b11 && yv == '0)
      a_r4_zero_shift: assert (z_data == x_opnd);
  end
endmodule

bind ctl_alu ctl_alu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
  .x_opnd     (x_opnd),
  .y_opnd     (y_opnd),
  .imm_val    (imm_val),
  .imm_en     (imm_en),
  .unit_sel   (unit_sel),
  .sub_mode   (sub_mode),
  .logic_fn   (logic_fn),
  .shift_kind (shift_kind),
  .alu_en     (alu_en),
  .z_data     (z_data),
  .z_drive    (z_drive)
);

// File: tb/ctl_alu_test.sv
module ctl_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic [W-1:0]  x_opnd = '0, y_opnd = '0;
  logic [IW-1:0] imm_val = '0;
  logic          imm_en = 1'b0, sub_mode = 1'b0, alu_en = 1'b0;
  logic [1:0]    unit_sel = 2'b00, shift_kind = 2'b00;
  logic [3:0]    logic_fn = 4'b0000;
  logic [W-1:0]  z_data;
  logic          z_drive;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_alu #(.W(W), .IMM_W(IW)) uut (
    .x_opnd(x_opnd), .y_opnd(y_opnd), .imm_val(imm_val), .imm_en(imm_en),
    .unit_sel(unit_sel), .sub_mode(sub_mode), .logic_fn(logic_fn),
    .shift_kind(shift_kind), .alu_en(alu_en), .z_data(z_data), .z_drive(z_drive)
  );

  function automatic logic [W-1:0] expect_z(
    input logic [W-1:0] x, input logic [W-1:0] y, input logic [IW-1:0] im,
    input logic ie, input logic [1:0] sel, input logic sb, input logic [3:0] lf,
    input logic [1:0] st, input logic en);
    logic [W-1:0] b, r, ab;
    int n;
    b  = ie ? {{(W-IW){im[IW-1]}}, im} : y;
    ab = b[W-1] ? -b : b;
    n  = int'(ab[4:0]);
    r  = '0;
    case (sel)
      2'b00: r = sb ? x - b : x + b;
      2'b10: r = (lf[3] ? (x & b) : '0) | (lf[2] ? (x & ~b) : '0) |
                 (lf[1] ? (~x & b) : '0) | (lf[0] ? (~x & ~b) : '0);
      2'b01: begin
        if (!b[W-1]) begin
          case (st)
            2'b00: r = x >> n;
            2'b01: r = $signed(x) >>> n;
            2'b10: r = (n == 0) ? x : ((x >> n) | (x << (W - n)));
            default: r = '0;
          endcase
        end else begin
          case (st)
            2'b00, 2'b01: r = x << n;
            2'b10: r = (n == 0) ? x : ((x << n) | (x >> (W - n)));
            default: r = '0;
          endcase
        end
      end
      default: r = '0;
    endcase
    return en ? r : '0;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [W-1:0] x, input logic [W-1:0] y,
                     input logic [IW-1:0] im, input logic ie, input logic [1:0] sel,
                     input logic sb, input logic [3:0] lf, input logic [1:0] st,
                     input logic en);
    @(negedge clk);
    x_opnd = x; y_opnd = y; imm_val = im; imm_en = ie; unit_sel = sel;
    sub_mode = sb; logic_fn = lf; shift_kind = st; alu_en = en;
    #1;
    check(tag, z_data, expect_z(x, y, im, ie, sel, sb, lf, st, en));
    check({tag, " flag"}, {{(W-1){1'b0}}, z_drive}, {{(W-1){1'b0}}, en});
  endtask

  task automatic t_reset_state();
    #1;
    check("R11 initial bus", z_data, '0);
    check("R11 initial flag", {{(W-1){1'b0}}, z_drive}, '0);
  endtask

  task automatic t_arith();
    run("R1 add", 32'h0000_1234, 32'h0000_0F0F, 8'h00, 1'b0, 2'b00, 1'b0, 4'h0, 2'b00, 1'b1);
    run("R1 add wrap", 32'hFFFF_FFFF, 32'h0000_0002, 8'h00, 1'b0, 2'b00, 1'b0, 4'h0, 2'b00, 1'b1);
    run("R2 sub", 32'h0000_0010, 32'h0000_0003, 8'h00, 1'b0, 2'b00, 1'b1, 4'h0, 2'b00, 1'b1);
    run("R2 sub borrow", 32'h0000_0000, 32'h0000_0001, 8'h00, 1'b0, 2'b00, 1'b1, 4'h0, 2'b00, 1'b1);
  endtask

  task automatic t_logic();
    logic [3:0] codes [5] = '{4'b1000, 4'b1110, 4'b0110, 4'b0101, 4'b1001};
    foreach (codes[k])
      run("R3 logic", 32'hF0F0_3C3C, 32'hFF00_5A5A, 8'h00, 1'b0, 2'b10, 1'b0, codes[k], 2'b00, 1'b1);
  endtask

  task automatic t_shift();
    run("R4 zero amount", 32'h8000_0001, 32'h0, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b01, 1'b1);
    run("R4 magnitude low bits", 32'h0000_FF00, 32'h0000_0024, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b00, 1'b1);
    run("R5 logical right", 32'h8000_F000, 32'h4, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b00, 1'b1);
    run("R5 logical left", 32'h8000_F00F, 32'hFFFF_FFFC, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b00, 1'b1);
    run("R6 arith right neg", 32'h8000_F000, 32'h8, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b01, 1'b1);
    run("R6 arith right pos", 32'h4000_F000, 32'h8, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b01, 1'b1);
    run("R6 arith left", 32'h8000_F00F, 32'hFFFF_FFF8, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b01, 1'b1);
    run("R7 rotate right", 32'h1234_5678, 32'h0000_000C, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b10, 1'b1);
    run("R7 rotate left", 32'h1234_5678, 32'hFFFF_FFF4, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b10, 1'b1);
    run("R7 rotate by 31", 32'h8000_0001, 32'h0000_001F, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b10, 1'b1);
  endtask

  task automatic t_reserved();
    run("R8 reserved shift kind", 32'hDEAD_BEEF, 32'h3, 8'h00, 1'b0, 2'b01, 1'b0, 4'h0, 2'b11, 1'b1);
    run("R9 reserved unit", 32'hDEAD_BEEF, 32'h3, 8'h00, 1'b0, 2'b11, 1'b0, 4'hF, 2'b00, 1'b1);
  endtask

  task automatic t_immediate();
    run("R10 imm shift right", 32'h8000_0100, 32'hFFFF_FFF0, 8'h01, 1'b1, 2'b01, 1'b0, 4'h0, 2'b01, 1'b1);
    run("R10 neg imm shift left", 32'h0000_0101, 32'h0000_0010, 8'hFE, 1'b1, 2'b01, 1'b0, 4'h0, 2'b00, 1'b1);
    run("R10 imm add sign ext", 32'h0000_0100, 32'h7777_7777, 8'h80, 1'b1, 2'b00, 1'b0, 4'h0, 2'b00, 1'b1);
    run("R10 imm logic", 32'hFFFF_00FF, 32'h0000_0000, 8'h3C, 1'b1, 2'b10, 1'b0, 4'b1000, 2'b00, 1'b1);
  endtask

  task automatic t_enable();
    run("R11 disabled add", 32'h0000_1111, 32'h0000_2222, 8'h00, 1'b0, 2'b00, 1'b0, 4'h0, 2'b00, 1'b0);
    run("R11 disabled logic", 32'hFFFF_FFFF, 32'h0, 8'h00, 1'b0, 2'b10, 1'b0, 4'b1111, 2'b00, 1'b0);
    run("R11 re-enabled", 32'h0000_1111, 32'h0000_2222, 8'h00, 1'b0, 2'b00, 1'b0, 4'h0, 2'b00, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_arith();
    t_logic();
    t_shift();
    t_reserved();
    t_immediate();
    t_enable();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule